// File: doc/BRIEF.md
# PCM Highway Transmit Time-Slot Multiplexer

This block drives the transmit data line of a serial PCM highway. It runs on its own transmit clock and keeps a bit position within the frame. The frame is aligned by a transmit sync pulse whose rising edge marks the bit now on the line as the last bit of the frame. For every bit position, the block finds the time slot and looks up that slot's entry in an external slot table. The entry holds an enable, a channel number and an 8-bit fill mask.

When the position carries channel data, the block requests one bit from the assigned channel in the cycle before that bit goes out. The returned bit is registered onto the line together with an output enable. The enable is dropped for positions that carry no data: masked bits, disabled slots, the T1 framing bit, and slots of the half that a 4.096 Mbit/s highway does not serve. A tri-state pad driven by `tx_oe` then leaves the line in high impedance at those positions.

Two external loop modes retransmit received line data in place of channel data. One mode covers all channels. The other covers only the positions of a single selected channel.

Top module: `pcm_tx_mux`

## Requirements
- R1: A sampled rising edge of `sync` makes the bit requested in that same cycle position 0 of a new frame, so `tsa_slot` is 0 in that cycle. If `sync` is held high, it does not realign the frame again.
- R2: Without a sync edge, the position counter wraps on its own at the frame length. The length is 256 bits for `fmt`=0 (32 slots), 193 bits for `fmt`=1 (24 slots plus a framing bit), 192 bits for `fmt`=2 (24 slots) and 512 bits for `fmt`=3 (64 slots).
- R3: `tsa_slot` carries the slot-table index. For `fmt` 0 to 2 it is the slot number. For `fmt`=3 it is the slot number shifted right by one.
- R4: Bits inside a slot go out MSB first. Bit b of a slot (b=0 is the first bit) carries data only when `tsa_mask[7-b]` is 1. A masked bit produces no request and goes out with `tx_oe` low.
- R5: When `tsa_en` is low, none of that slot's bits is requested or enabled.
- R6: For `fmt`=1, position 0 of the frame is the framing bit. It goes out with `tx_oe` low, and slot 0 starts at position 1.
- R7: For `fmt`=3, only slots whose least significant bit equals `half_sel` are served. All other slots go out with `tx_oe` low.
- R8: A request (`req_valid` high with `req_ch`) is made in the cycle before its bit is driven. `req_data` is sampled at the edge that ends that cycle and appears on `tx_data` with `tx_oe` high.
- R9: When `loop_mode`=1, no request is made. Every enabled position drives the `rx_data` value sampled at the same edge.
- R10: When `loop_mode`=2, enabled positions whose channel equals `loop_ch` drive sampled `rx_data` and make no request. All other positions behave normally. Any other `loop_mode` value disables looping.
- R11: While `rst_n` is low, `tx_oe` and `tx_data` are 0.
- R12: Whenever `tx_oe` is low, `tx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 2 | Highway format: 0 = 32 slots, 1 = 24 slots plus framing bit, 2 = 24 slots, 3 = 64 slots with half served |
| half_sel | input | 1 | Served half for format 3: 0 = even slots, 1 = odd slots |
| sync | input | 1 | Transmit sync; rising edge marks the current line bit as last of the frame |
| tsa_slot | output | 5 | Slot-table index for the position requested this cycle |
| tsa_en | input | 1 | Slot-table entry enable |
| tsa_ch | input | CH_W | Channel assigned to the slot |
| tsa_mask | input | 8 | Fill mask; bit 7 covers the first bit of the slot |
| req_valid | output | 1 | Bit request strobe |
| req_ch | output | CH_W | Channel whose bit is requested |
| req_data | input | 1 | Requested bit, valid in the request cycle |
| loop_mode | input | 2 | 0 = normal, 1 = loop all channels, 2 = loop one channel |
| loop_ch | input | CH_W | Channel looped in mode 2 |
| rx_data | input | 1 | Received line data, already in the transmit clock domain |
| tx_data | output | 1 | Transmit line data |
| tx_oe | output | 1 | Transmit line output enable |

## Verification
The lookup index, `req_valid` and `req_ch` follow the current position in the same cycle, including the cycle in which a sync edge is presented. The bench therefore reads them 1 ns after it drives that cycle's inputs. `tx_data` and `tx_oe` carry the result of a request one clock edge later. The bench stores the expected line bit for each request and compares it at the next falling edge, before any input changes. Frame positions are tracked in the bench from its own sync pulses and the frame length of each format. The second frame of every run has no sync, so it also checks the automatic wrap.

// File: rtl/pcm_tx_mux.sv
module pcm_tx_mux #(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      fmt,
  input  logic            half_sel,
  input  logic            sync,
  output logic [4:0]      tsa_slot,
  input  logic            tsa_en,
  input  logic [CH_W-1:0] tsa_ch,
  input  logic [7:0]      tsa_mask,
  output logic            req_valid,
  output logic [CH_W-1:0] req_ch,
  input  logic            req_data,
  input  logic [1:0]      loop_mode,
  input  logic [CH_W-1:0] loop_ch,
  input  logic            rx_data,
  output logic            tx_data,
  output logic            tx_oe
);
  localparam int POS_W = 9;

  logic             sync_q;
  logic [POS_W-1:0] pos_cnt, cur_pos, last_pos, sl_pos;
  logic [5:0]       slot;
  logic [2:0]       bitn;
  logic             sync_rise, fbit, served, active, looped;

  assign sync_rise = sync & ~sync_q;
  assign cur_pos   = sync_rise ? '0 : pos_cnt;

  always_comb begin
    case (fmt)
      2'd0:    last_pos = POS_W'(255);
      2'd1:    last_pos = POS_W'(192);
      2'd2:    last_pos = POS_W'(191);
      default: last_pos = POS_W'(511);
    endcase
  end

  assign fbit   = (fmt == 2'd1) && (cur_pos == '0);
  assign sl_pos = (fmt == 2'd1 && !fbit) ? cur_pos - POS_W'(1) : cur_pos;
  assign slot   = sl_pos[POS_W-1:3];
  assign bitn   = sl_pos[2:0];
  assign served = (fmt != 2'd3) || (slot[0] == half_sel);

  assign tsa_slot = (fmt == 2'd3) ? slot[5:1] : slot[4:0];

  assign active = !fbit && served && tsa_en && tsa_mask[3'd7 - bitn];
  assign looped = (loop_mode == 2'd1) || (loop_mode == 2'd2 && tsa_ch == loop_ch);

  assign req_valid = active && !looped;
  assign req_ch    = tsa_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b1;
      pos_cnt <= '0;
      tx_oe   <= 1'b0;
      tx_data <= 1'b0;
    end else begin
      sync_q  <= sync;
      pos_cnt <= (cur_pos == last_pos) ? '0 : cur_pos + POS_W'(1);
      tx_oe   <= active;
      tx_data <= active && (looped ? rx_data : req_data);
    end
  end

  a_r1_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise |-> tsa_slot == 5'd0);

  a_r5_disabled_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !tsa_en |-> !req_valid);

  a_r6_fbit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rise && fmt == 2'd1) |=> !tx_oe);

  a_r8_req_driven: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (tx_oe && tx_data == $past(req_data)));

  a_r9_loop_all_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    loop_mode == 2'd1 |-> !req_valid);

  a_r12_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_oe |-> !tx_data);

endmodule

// File: tb/pcm_tx_mux_bench.sv
module pcm_tx_mux_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic        half_sel = 1'b0;
  logic        sync = 1'b0;
  logic [4:0]  tsa_slot;
  logic        tsa_en;
  logic [4:0]  tsa_ch;
  logic [7:0]  tsa_mask;
  logic        req_valid;
  logic [4:0]  req_ch;
  logic        req_data;
  logic [1:0]  loop_mode = 2'd0;
  logic [4:0]  loop_ch = 5'h0B;
  logic        rx_data = 1'b0;
  logic        tx_data;
  logic        tx_oe;

  logic [31:0] kcyc = '0;
  int nchk = 0, nfail = 0;
  bit prev_sync = 1'b1, known = 1'b0, pend_v = 1'b0, pend_oe, pend_data;
  bit cnt_req_on = 1'b0, cnt_oe_on = 1'b0;
  int bpos = 0, cnt_req = 0, cnt_oe = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mask_of(input logic [1:0] k);
    case (k)
      2'd0: return 8'hFF;
      2'd1: return 8'h80;
      2'd2: return 8'hF0;
      default: return 8'hFF;
    endcase
  endfunction

  assign tsa_en   = (tsa_slot[1:0] != 2'd3);
  assign tsa_ch   = tsa_slot ^ 5'h0A;
  assign tsa_mask = mask_of(tsa_slot[1:0]);
  assign req_data = kcyc[0] ^ req_ch[0] ^ req_ch[2];

  pcm_tx_mux #(.CH_W(5)) u_pcm_tx_mux (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .half_sel(half_sel), .sync(sync),
    .tsa_slot(tsa_slot), .tsa_en(tsa_en), .tsa_ch(tsa_ch), .tsa_mask(tsa_mask),
    .req_valid(req_valid), .req_ch(req_ch), .req_data(req_data),
    .loop_mode(loop_mode), .loop_ch(loop_ch), .rx_data(rx_data),
    .tx_data(tx_data), .tx_oe(tx_oe));

  function automatic int frame_len(input logic [1:0] f);
    case (f)
      2'd0: return 256;
      2'd1: return 193;
      2'd2: return 192;
      default: return 512;
    endcase
  endfunction

  // returns {enabled, channel}
  function automatic logic [5:0] model(input logic [1:0] f, input logic h, input int p);
    int q, sl, b, idx;
    logic [7:0] mk;
    if (f == 2'd1) begin
      if (p == 0) return 6'd0;
      q = p - 1;
    end else q = p;
    sl = q / 8;
    b  = q % 8;
    if (f == 2'd3) begin
      if ((sl % 2) != int'(h)) return 6'd0;
      idx = sl / 2;
    end else idx = sl;
    if (idx % 4 == 3) return 6'd0;
    mk = mask_of(2'(idx % 4));
    return {mk[7-b], 5'(idx) ^ 5'h0A};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit s, input logic [1:0] f, input logic h, input logic [1:0] lm);
    logic [5:0] m;
    bit lp, exp_req;
    @(negedge clk);
    if (pend_v) begin
      chk(tx_oe == pend_oe, "R4/R5/R6/R7 line enable", tx_oe, pend_oe);
      chk(tx_data == pend_data, "R8/R9/R10 line data", tx_data, pend_data);
    end
    if (cnt_oe_on && tx_oe) cnt_oe++;
    kcyc = kcyc + 1;
    fmt = f; half_sel = h; loop_mode = lm;
    rx_data = kcyc[1] ^ kcyc[3];
    sync = s;
    if (s && !prev_sync) begin bpos = 0; known = 1'b1; end
    else if (known) bpos = (bpos == frame_len(f) - 1) ? 0 : bpos + 1;
    #1;
    if (s && !prev_sync) chk(tsa_slot == 5'd0, "R1 frame start index", tsa_slot, 0);
    prev_sync = s;
    if (cnt_req_on && req_valid) cnt_req++;
    if (known) begin
      m = model(f, h, bpos);
      lp = (lm == 2'd1) || (lm == 2'd2 && m[4:0] == loop_ch);
      exp_req = m[5] && !lp;
      chk(req_valid == exp_req, "R4/R5/R9/R10 request", req_valid, exp_req);
      if (exp_req) chk(req_ch == m[4:0], "R3 request channel", req_ch, m[4:0]);
      pend_v = 1'b1;
      pend_oe = m[5];
      pend_data = m[5] && (lp ? rx_data : (kcyc[0] ^ m[0] ^ m[2]));
    end else pend_v = 1'b0;
  endtask

  // {fmt, half, loop, oe per frame, requests per frame}
  localparam logic [24:0] VEC [9] = '{
    {2'd0, 1'b0, 2'd0, 10'd104, 10'd104},
    {2'd1, 1'b0, 2'd0, 10'd78,  10'd78},
    {2'd2, 1'b0, 2'd0, 10'd78,  10'd78},
    {2'd3, 1'b0, 2'd0, 10'd104, 10'd104},
    {2'd3, 1'b1, 2'd0, 10'd104, 10'd104},
    {2'd0, 1'b0, 2'd1, 10'd104, 10'd0},
    {2'd0, 1'b0, 2'd2, 10'd104, 10'd103},
    {2'd1, 1'b0, 2'd2, 10'd78,  10'd77},
    {2'd3, 1'b1, 2'd2, 10'd104, 10'd103}
  };

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) begin
      @(negedge clk);
      chk(tx_oe == 1'b0, "R11 reset enable", tx_oe, 0);
      chk(tx_data == 1'b0, "R11 reset data", tx_data, 0);
    end
    rst_n = 1'b1;
    repeat (4) step(1'b0, 2'd0, 1'b0, 2'd0);

    for (int r = 0; r < 9; r++) begin
      logic [1:0] f, lm;
      logic h;
      int len;
      {f, h, lm} = VEC[r][24:20];
      len = frame_len(f);
      cnt_req = 0; cnt_oe = 0;
      // sync held two cycles: only the first edge aligns (R1); second frame wraps alone (R2)
      for (int j = 0; j < 2 * len + 2; j++) begin
        cnt_req_on = (j < len);
        cnt_oe_on  = (j >= 1 && j <= len);
        step(j < 2, f, h, lm);
      end
      cnt_req_on = 1'b0; cnt_oe_on = 1'b0;
      chk(cnt_oe == int'(VEC[r][19:10]), "R2/R4/R6/R7 enabled bits per frame", cnt_oe, VEC[r][19:10]);
      chk(cnt_req == int'(VEC[r][9:0]), "R9/R10 requests per frame", cnt_req, VEC[r][9:0]);
      repeat (3) step(1'b0, f, h, lm);
    end

    // R1 mid-frame realignment
    step(1'b1, 2'd0, 1'b0, 2'd0);
    for (int j = 0; j < 36; j++) step(1'b0, 2'd0, 1'b0, 2'd0);
    step(1'b1, 2'd0, 1'b0, 2'd0);
    chk(req_valid == 1'b1, "R1 realigned first bit requested", req_valid, 1);
    for (int j = 0; j < 20; j++) step(1'b0, 2'd0, 1'b0, 2'd0);

    // R11 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(tx_oe == 1'b0, "R11 mid-run reset enable", tx_oe, 0);
    chk(tx_data == 1'b0, "R11 mid-run reset data", tx_data, 0);
    pend_v = 1'b0; known = 1'b0; prev_sync = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 2'd0, 1'b0, 2'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule